// File: doc/BRIEF.md
# Gated Double-Buffer Framebuffer Writer

This block moves pixel write requests from the head of a clock-crossing FIFO into external memory. It also owns the bit that tells the display which of two framebuffers to scan. Each FIFO entry carries a column, a row and a color. The writer always aims each pixel at the buffer the display is not showing.

The decision about which buffer to target is made when the entry is taken from the head of the FIFO. It is not made when the entry was enqueued. Firmware can freeze the display/render assignment for a whole multi-frame render. It writes 1 to an inhibit control bit in the compute clock domain. That bit is carried into the pixel clock domain through two flops. While it is set, vertical sync edges do not swap the buffers. Writing 0 releases the freeze, and the swap waiting behind it happens at the following vertical sync edge.

Requests leave on a dedicated memory port when that port reports ready. Otherwise they go to a shared arbitration path. The writer runs its own three-state sequencer (idle, request, wait for acknowledge). It removes an entry only when the memory acknowledges the write.

Top module: `fb_swap_writer`

## Requirements
- R1: `wr_addr` is 18 bits. Bit 17 is the target buffer, bits 16:9 are the row `fifo_y`, and bits 8:0 are the column `fifo_x`. `wr_data` carries the entry's color.
- R2: The target buffer bit is the inverse of `disp_sel` as seen in the memory clock domain, after a two-flop synchronizer.
- R3: While inhibit is clear, `disp_sel` inverts once for each rising edge of `vsync`. A `vsync` held high causes no further inversion, and `disp_sel` changes at no other time.
- R4: A control write with `ctl_wdata`=1 sets the inhibit. From the third pixel clock edge after that write onward, rising `vsync` edges leave `disp_sel` unchanged.
- R5: A control write with `ctl_wdata`=0 clears the inhibit. `disp_sel` does not change until the next rising `vsync` edge, and it inverts once at that edge.
- R6: The target buffer is taken from the synchronized display select in the cycle the writer leaves idle for a non-empty FIFO. A swap that happened while the entry waited behind an empty flag or a busy writer is reflected in its address.
- R7: If `port1_ready` is high when a request is formed, the request goes out on `req_port1`. Otherwise it goes out on `req_arb`. The two are never high together.
- R8: A request is a one-cycle strobe, followed by a wait for `wr_ack` with no repeated strobe. `fifo_pop` is high only in the cycle `wr_ack` arrives during that wait, and never while the FIFO is empty.
- R9: After reset, `disp_sel` is 0, the inhibit is clear, and `req_port1`, `req_arb` and `fifo_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Compute clock, drives the inhibit control bit |
| pix_clk | input | 1 | Pixel clock, drives vsync sampling and the display select |
| mem_clk | input | 1 | Memory clock, drives the drain sequencer |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ctl_we | input | 1 | Control write strobe for the inhibit bit (cpu_clk) |
| ctl_wdata | input | 1 | Value written to the inhibit bit |
| vsync | input | 1 | Vertical sync (pix_clk) |
| disp_sel | output | 1 | Buffer currently scanned by the display |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_x | input | 9 | Column of the head entry |
| fifo_y | input | 8 | Row of the head entry |
| fifo_color | input | 16 | Color of the head entry |
| fifo_pop | output | 1 | Remove the head entry |
| port1_ready | input | 1 | Dedicated write port can take a request |
| req_port1 | output | 1 | Request strobe on the dedicated port |
| req_arb | output | 1 | Request strobe on the arbitrated path |
| wr_addr | output | 18 | Write address {buffer, row, column} |
| wr_data | output | 16 | Write data |
| wr_ack | input | 1 | Memory accepted the write |

## Verification
If the display select were kept wrong, `disp_sel` would show it at the first vsync edge. Through the synchronizer, bit 17 of the next write address would show the same error a few memory cycles later. A stuck or leaky inhibit synchronizer shows up on the first vsync pulse after a control write: either a swap that should have been blocked, or a swap that should have happened and did not. If the sequencer's state were wrong, it would appear within one or two memory cycles of the request. The signs are a repeated or missing strobe, a pop without an acknowledge, or the wrong port being chosen.

// File: rtl/fb_swap_writer.sv
module fb_swap_writer #(
  parameter int XW = 9,
  parameter int YW = 8,
  parameter int CW = 16
) (
  input  logic             cpu_clk,
  input  logic             pix_clk,
  input  logic             mem_clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_wdata,
  input  logic             vsync,
  output logic             disp_sel,
  input  logic             fifo_empty,
  input  logic [XW-1:0]    fifo_x,
  input  logic [YW-1:0]    fifo_y,
  input  logic [CW-1:0]    fifo_color,
  output logic             fifo_pop,
  input  logic             port1_ready,
  output logic             req_port1,
  output logic             req_arb,
  output logic [XW+YW:0]   wr_addr,
  output logic [CW-1:0]    wr_data,
  input  logic             wr_ack
);
  localparam int AW = XW + YW + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} drain_t;

  logic inh_cpu;
  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n)      inh_cpu <= 1'b0;
    else if (ctl_we) inh_cpu <= ctl_wdata;

  logic inh_p1, inh_p2, vsync_q;
  always_ff @(posedge pix_clk or negedge rst_n)
    if (!rst_n) begin
      inh_p1   <= 1'b0;
      inh_p2   <= 1'b0;
      vsync_q  <= 1'b0;
      disp_sel <= 1'b0;
    end else begin
      inh_p1  <= inh_cpu;
      inh_p2  <= inh_p1;
      vsync_q <= vsync;
      if (vsync && !vsync_q && !inh_p2) disp_sel <= ~disp_sel;
    end

  logic sel_m1, sel_m2;
  always_ff @(posedge mem_clk or negedge rst_n)
    if (!rst_n) begin
      sel_m1 <= 1'b0;
      sel_m2 <= 1'b0;
    end else begin
      sel_m1 <= disp_sel;
      sel_m2 <= sel_m1;
    end

  drain_t          state;
  logic            use_p1;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   data_q;

  always_ff @(posedge mem_clk or negedge rst_n)
    if (!rst_n) begin
      state  <= ST_IDLE;
      use_p1 <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!fifo_empty) begin
          addr_q <= {~sel_m2, fifo_y, fifo_x};
          data_q <= fifo_color;
          use_p1 <= port1_ready;
          state  <= ST_REQ;
        end
        ST_REQ:  state <= ST_WAIT;
        ST_WAIT: if (wr_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end

  assign req_port1 = (state == ST_REQ) &&  use_p1;
  assign req_arb   = (state == ST_REQ) && !use_p1;
  assign fifo_pop  = (state == ST_WAIT) && wr_ack;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
endmodule

// File: rtl/fb_swap_writer_chk.sv
module fb_swap_writer_chk (
  input logic pix_clk,
  input logic mem_clk,
  input logic rst_n,
  input logic vsync,
  input logic disp_sel,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic req_port1,
  input logic req_arb,
  input logic wr_ack,
  input logic [17:0] wr_addr
);
  // R7
  port_excl_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
    $onehot0({req_port1, req_arb}));

  // R8
  pop_needs_ack_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
    fifo_pop |-> (wr_ack && !fifo_empty));

  // R8
  single_strobe_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
    (req_port1 || req_arb) |=> !(req_port1 || req_arb));

  // R1
  addr_hold_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
    (req_port1 || req_arb) |=> $stable(wr_addr));

  // R3
  swap_on_edge_chk: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (disp_sel != $past(disp_sel)) |-> ($past(vsync) && !$past(vsync, 2)));
endmodule

bind fb_swap_writer fb_swap_writer_chk u_chk (
  .pix_clk(pix_clk), .mem_clk(mem_clk), .rst_n(rst_n), .vsync(vsync),
  .disp_sel(disp_sel), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .req_port1(req_port1), .req_arb(req_arb), .wr_ack(wr_ack), .wr_addr(wr_addr)
);

// File: tb/fb_swap_writer_tb.sv
module fb_swap_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_PERIOD = 14;
  localparam int CPU_PERIOD = 12;

  logic cpu_clk = 0, pix_clk = 0, mem_clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_wdata = 0, vsync = 0;
  logic fifo_empty = 1, port1_ready = 0, wr_ack = 0;
  logic [8:0] fifo_x = 0;
  logic [7:0] fifo_y = 0;
  logic [15:0] fifo_color = 0;
  logic disp_sel, fifo_pop, req_port1, req_arb;
  logic [17:0] wr_addr;
  logic [15:0] wr_data;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) mem_clk = ~mem_clk;
  always #(PIX_PERIOD/2) pix_clk = ~pix_clk;
  always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;

  fb_swap_writer u_dut (
    .cpu_clk(cpu_clk), .pix_clk(pix_clk), .mem_clk(mem_clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .vsync(vsync), .disp_sel(disp_sel),
    .fifo_empty(fifo_empty), .fifo_x(fifo_x), .fifo_y(fifo_y),
    .fifo_color(fifo_color), .fifo_pop(fifo_pop), .port1_ready(port1_ready),
    .req_port1(req_port1), .req_arb(req_arb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic v);
    @(negedge cpu_clk); ctl_we = 1; ctl_wdata = v;
    @(negedge cpu_clk); ctl_we = 0;
    repeat (5) @(negedge pix_clk);
  endtask

  task automatic vs_pulse(input int hold);
    @(negedge pix_clk); vsync = 1;
    repeat (hold) @(negedge pix_clk);
    vsync = 0;
    repeat (3) @(negedge pix_clk);
  endtask

  // Drive one FIFO entry and act as memory; checks R1/R2/R7/R8 on the way.
  task automatic drain_one(input logic [8:0] x, input logic [7:0] y, input logic [15:0] c,
                           input logic p1, input int ack_delay, input string tag);
    logic exp_buf;
    bit seen;
    repeat (6) @(negedge mem_clk);
    exp_buf = ~disp_sel;
    fifo_x = x; fifo_y = y; fifo_color = c; port1_ready = p1; fifo_empty = 0;
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge mem_clk);
      if (req_port1 || req_arb) seen = 1;
    end
    chk(seen, {tag, " R8 request"}, seen, 1);
    chk(wr_addr == {exp_buf, y, x}, {tag, " R1 R2 address"}, wr_addr, {exp_buf, y, x});
    chk(wr_data == c, {tag, " R1 data"}, wr_data, c);
    chk(req_port1 == p1 && req_arb == !p1, {tag, " R7 port"}, {req_port1, req_arb}, {p1, !p1});
    for (int i = 0; i < ack_delay; i++) begin
      @(negedge mem_clk);
      chk(!req_port1 && !req_arb && !fifo_pop, {tag, " R8 quiet while waiting"},
          {req_port1, req_arb, fifo_pop}, 0);
    end
    @(negedge mem_clk); wr_ack = 1; #1;
    chk(fifo_pop == 1, {tag, " R8 pop on ack"}, fifo_pop, 1);
    @(negedge mem_clk); wr_ack = 0; fifo_empty = 1; #1;
    chk(fifo_pop == 0, {tag, " R8 single pop"}, fifo_pop, 0);
  endtask

  task automatic t_reset;
    chk(disp_sel == 0, "R9 disp_sel", disp_sel, 0);
    chk(!req_port1 && !req_arb, "R9 no request", {req_port1, req_arb}, 0);
    chk(fifo_pop == 0, "R9 no pop", fifo_pop, 0);
    vs_pulse(2);
    chk(disp_sel == 1, "R9 inhibit clear after reset", disp_sel, 1);
  endtask

  task automatic t_swap;
    logic s;
    s = disp_sel;
    vs_pulse(2);
    chk(disp_sel == ~s, "R3 toggle on edge", disp_sel, ~s);
    vs_pulse(12);
    chk(disp_sel == s, "R3 held vsync toggles once", disp_sel, s);
    repeat (10) @(negedge pix_clk);
    chk(disp_sel == s, "R3 no toggle without edge", disp_sel, s);
  endtask

  task automatic t_inhibit;
    logic s;
    s = disp_sel;
    ctl_write(1);
    for (int k = 0; k < 3; k++) vs_pulse(2);
    chk(disp_sel == s, "R4 inhibited swap", disp_sel, s);
    ctl_write(0);
    repeat (10) @(negedge pix_clk);
    chk(disp_sel == s, "R5 no swap before vsync", disp_sel, s);
    vs_pulse(2);
    chk(disp_sel == ~s, "R5 swap at next vsync", disp_sel, ~s);
  endtask

  task automatic t_drain;
    drain_one(9'h1A5, 8'hC3, 16'hBEEF, 1, 0, "p1");
    drain_one(9'h0FF, 8'h00, 16'h1234, 0, 4, "arb");
    vs_pulse(2);
    drain_one(9'h000, 8'hEF, 16'hA5A5, 1, 2, "after swap");
  endtask

  task automatic t_drain_time;
    logic s;
    fifo_x = 9'h055; fifo_y = 8'h66; fifo_color = 16'h7777; port1_ready = 1;
    s = disp_sel;
    vs_pulse(2);
    repeat (6) @(negedge mem_clk);
    fifo_empty = 0;
    @(negedge mem_clk); @(negedge mem_clk);
    chk(wr_addr[17] == s, "R6 buffer chosen at drain", wr_addr[17], s);
    @(negedge mem_clk); wr_ack = 1;
    @(negedge mem_clk); wr_ack = 0; fifo_empty = 1;
    repeat (3) @(negedge mem_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge mem_clk);
    rst_n = 1;
    repeat (4) @(negedge pix_clk);
    t_reset();
    t_swap();
    t_inhibit();
    t_drain();
    t_drain_time();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule